// File: doc/BRIEF.md
# Speculative Global History Register

This block holds one global branch-direction history register for each hardware thread. The register is updated speculatively, as soon as a direction is known or predicted. Each time a prediction is made, the block returns the thread's history as it stood before that prediction. It also files a copy in a small checkpoint table, under a prediction ID chosen by the front end.

Later events use that checkpoint to repair the history. A direction update shifts the taken bit into the register. A misprediction rebuilds the register from the checkpoint and the true outcome, and the checkpoint stays live. A discarded prediction puts the checkpoint back unchanged and frees its entry. A commit frees the entry and leaves the history alone.

The checkpoint remembers which thread it belongs to, so rebuild and restore take no thread input. A history width larger than the storage width is rejected at elaboration.

Top module: `ghr_spec_hist`

## Requirements
- R1: A direction update on thread t sets that thread's history to ((old << 1) | taken), truncated to HIST_W bits. The low bit holds the newest outcome.
- R2: On a prediction, `pred_snap` shows the chosen thread's history before any update in the same cycle. After the edge, entry `pred_id` is live and holds that value and that thread.
- R3: A correction on a live entry sets the entry's thread's history to ((snapshot << 1) | fix_taken), truncated to HIST_W bits. The entry stays live.
- R4: A discard on a live entry sets the entry's thread's history to the snapshot exactly and frees the entry.
- R5: A commit frees its entry and changes no history register.
- R6: When several events touch the same thread in one cycle, discard beats correction and correction beats direction update.
- R7: A correction or discard naming an entry that is not live changes no history register.
- R8: Events on one thread leave every other thread's history unchanged.
- R9: After reset, every history register is zero and no entry is live.
- R10: A prediction that allocates an entry in the same cycle as a commit or discard frees that entry leaves the entry live, holding the new snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Direction update strobe |
| upd_tid | input | TID_W | Thread of the direction update |
| upd_taken | input | 1 | Taken outcome to shift in |
| pred_valid | input | 1 | Prediction strobe; takes a checkpoint |
| pred_tid | input | TID_W | Thread of the prediction |
| pred_id | input | ID_W | Checkpoint entry to fill |
| pred_snap | output | STORE_W | History before this prediction, zero-extended |
| fix_valid | input | 1 | Misprediction correction strobe |
| fix_id | input | ID_W | Checkpoint to rebuild from |
| fix_taken | input | 1 | True direction outcome |
| drop_valid | input | 1 | Discard strobe; restores and frees the checkpoint |
| drop_id | input | ID_W | Checkpoint to restore |
| retire_valid | input | 1 | Commit strobe; frees the checkpoint |
| retire_id | input | ID_W | Checkpoint to free |
| obs_tid | input | TID_W | Thread whose history is shown on obs_hist |
| obs_hist | output | STORE_W | Selected thread's history, zero-extended |
| live_map | output | NUM_CKPT | One bit per checkpoint entry, set while it is live |

## Verification
The bench builds the block with HIST_W = 6, STORE_W = 8, two threads and sixteen entries. With a 6-bit history, a run of seven updates pushes bits past the top, so truncation is exercised on the shift path and on the rebuild path. Two threads expose the per-thread routing of checkpoints and the isolation between threads. Sixteen entries let the tests keep several checkpoints live at once and reuse an ID in the same cycle it is freed.

// File: rtl/ghr_spec_pkg.sv
package ghr_spec_pkg;

   // Action applied to one thread's history in a cycle
   typedef enum logic [1:0] {
      GH_HOLD    = 2'd0,
      GH_SHIFT   = 2'd1,
      GH_REBUILD = 2'd2,
      GH_RESTORE = 2'd3
   } gh_act_e;

endpackage

// File: rtl/ghr_ckpt_table.sv
module ghr_ckpt_table #(
   parameter int NUM_CKPT = 16,
   parameter int HIST_W   = 12,
   parameter int TID_W    = 1,
   localparam int ID_W    = $clog2(NUM_CKPT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ID_W-1:0]   wr_id,
   input  logic [TID_W-1:0]  wr_tid,
   input  logic [HIST_W-1:0] wr_hist,
   input  logic [ID_W-1:0]   fix_id,
   output logic              fix_live,
   output logic [TID_W-1:0]  fix_tid,
   output logic [HIST_W-1:0] fix_hist,
   input  logic              drop_valid,
   input  logic [ID_W-1:0]   drop_id,
   output logic              drop_live,
   output logic [TID_W-1:0]  drop_tid,
   output logic [HIST_W-1:0] drop_hist,
   input  logic              retire_valid,
   input  logic [ID_W-1:0]   retire_id,
   output logic [NUM_CKPT-1:0] live
);

   logic [NUM_CKPT-1:0] live_q;
   logic [TID_W-1:0]    tid_q  [NUM_CKPT];
   logic [HIST_W-1:0]   hist_q [NUM_CKPT];

   assign live      = live_q;
   assign fix_live  = live_q[fix_id];
   assign fix_tid   = tid_q[fix_id];
   assign fix_hist  = hist_q[fix_id];
   assign drop_live = live_q[drop_id];
   assign drop_tid  = tid_q[drop_id];
   assign drop_hist = hist_q[drop_id];

   for (genvar e = 0; e < NUM_CKPT; e++) begin : g_ent
      logic set_e, clr_e;
      assign set_e = wr_en && (wr_id == ID_W'(e));
      assign clr_e = (retire_valid && (retire_id == ID_W'(e))) ||
                     (drop_valid && (drop_id == ID_W'(e)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live_q[e] <= 1'b0;
            tid_q[e]  <= '0;
            hist_q[e] <= '0;
         end else if (set_e) begin
            live_q[e] <= 1'b1;
            tid_q[e]  <= wr_tid;
            hist_q[e] <= wr_hist;
         end else if (clr_e) begin
            live_q[e] <= 1'b0;
         end
      end
   end

   // R2: a capture is live and holds the offered history afterwards
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> live_q[$past(wr_id)] && hist_q[$past(wr_id)] == $past(wr_hist)
                && tid_q[$past(wr_id)] == $past(wr_tid));

   // R5: commit frees the entry unless reallocated in that cycle
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !(wr_en && wr_id == retire_id)) |=> !live_q[$past(retire_id)]);

   // R10: allocation wins over a same-cycle free
   a_r10_alloc_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((retire_valid && retire_id == wr_id) || (drop_valid && drop_id == wr_id)))
      |=> live_q[$past(wr_id)]);

endmodule

// File: rtl/ghr_hist_lane.sv
module ghr_hist_lane
   import ghr_spec_pkg::*;
#(
   parameter int HIST_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  gh_act_e           act,
   input  logic              new_bit,
   input  logic [HIST_W-1:0] base,
   output logic [HIST_W-1:0] hist
);

   logic [HIST_W-1:0] hist_q, hist_d;
   logic [HIST_W:0]   shifted_cur, shifted_base;

   assign shifted_cur  = {hist_q, new_bit};
   assign shifted_base = {base, new_bit};

   always_comb begin
      unique case (act)
         GH_SHIFT:   hist_d = shifted_cur[HIST_W-1:0];
         GH_REBUILD: hist_d = shifted_base[HIST_W-1:0];
         GH_RESTORE: hist_d = base;
         default:    hist_d = hist_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= hist_d;
   end

   assign hist = hist_q;

   // R1: newest outcome lands in bit 0, older bits move up
   a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
      act == GH_SHIFT |=> hist_q[0] == $past(new_bit)
                          && hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

   // R3: rebuild from checkpoint plus true outcome
   a_r3_rebuild: assert property (@(posedge clk) disable iff (!rst_n)
      act == GH_REBUILD |=> hist_q[0] == $past(new_bit)
                            && hist_q[HIST_W-1:1] == $past(base[HIST_W-2:0]));

   // R4: restore is exact
   a_r4_restore: assert property (@(posedge clk) disable iff (!rst_n)
      act == GH_RESTORE |=> hist_q == $past(base));

   // R8: an idle lane keeps its value
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      act == GH_HOLD |=> $stable(hist_q));

endmodule

// File: rtl/ghr_spec_hist.sv
module ghr_spec_hist
   import ghr_spec_pkg::*;
#(
   parameter int NUM_THREADS = 2,
   parameter int HIST_W      = 12,
   parameter int STORE_W     = 16,
   parameter int NUM_CKPT    = 16,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int ID_W       = $clog2(NUM_CKPT)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_valid,
   input  logic [TID_W-1:0]    upd_tid,
   input  logic                upd_taken,
   input  logic                pred_valid,
   input  logic [TID_W-1:0]    pred_tid,
   input  logic [ID_W-1:0]     pred_id,
   output logic [STORE_W-1:0]  pred_snap,
   input  logic                fix_valid,
   input  logic [ID_W-1:0]     fix_id,
   input  logic                fix_taken,
   input  logic                drop_valid,
   input  logic [ID_W-1:0]     drop_id,
   input  logic                retire_valid,
   input  logic [ID_W-1:0]     retire_id,
   input  logic [TID_W-1:0]    obs_tid,
   output logic [STORE_W-1:0]  obs_hist,
   output logic [NUM_CKPT-1:0] live_map
);

   // Elaboration-time parameter checks
   if (HIST_W > STORE_W) begin : g_bad_width
      $error("HIST_W exceeds STORE_W");
   end
   if (HIST_W < 2) begin : g_bad_min
      $error("HIST_W must be at least 2");
   end
   if ((1 << ID_W) != NUM_CKPT) begin : g_bad_depth
      $error("NUM_CKPT must be a power of two");
   end
   if (NUM_THREADS < 1) begin : g_bad_thr
      $error("NUM_THREADS must be positive");
   end

   logic [HIST_W-1:0] lane_hist [NUM_THREADS];
   logic [HIST_W-1:0] sel_pred, sel_obs;

   logic              fix_live, drop_live;
   logic [TID_W-1:0]  fix_tid, drop_tid;
   logic [HIST_W-1:0] fix_hist, drop_hist;
   logic              fix_hit, drop_hit;

   always_comb begin
      sel_pred = '0;
      sel_obs  = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (pred_tid == TID_W'(t)) sel_pred = lane_hist[t];
         if (obs_tid  == TID_W'(t)) sel_obs  = lane_hist[t];
      end
   end

   assign pred_snap = STORE_W'(sel_pred);
   assign obs_hist  = STORE_W'(sel_obs);

   ghr_ckpt_table #(
      .NUM_CKPT (NUM_CKPT),
      .HIST_W   (HIST_W),
      .TID_W    (TID_W)
   ) u_tab (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (pred_valid),
      .wr_id        (pred_id),
      .wr_tid       (pred_tid),
      .wr_hist      (sel_pred),
      .fix_id       (fix_id),
      .fix_live     (fix_live),
      .fix_tid      (fix_tid),
      .fix_hist     (fix_hist),
      .drop_valid   (drop_valid),
      .drop_id      (drop_id),
      .drop_live    (drop_live),
      .drop_tid     (drop_tid),
      .drop_hist    (drop_hist),
      .retire_valid (retire_valid),
      .retire_id    (retire_id),
      .live         (live_map)
   );

   assign fix_hit  = fix_valid  && fix_live;
   assign drop_hit = drop_valid && drop_live;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
      gh_act_e           act;
      logic              nbit;
      logic [HIST_W-1:0] base;

      always_comb begin
         act  = GH_HOLD;
         nbit = 1'b0;
         base = '0;
         if (drop_hit && drop_tid == TID_W'(t)) begin
            act  = GH_RESTORE;
            base = drop_hist;
         end else if (fix_hit && fix_tid == TID_W'(t)) begin
            act  = GH_REBUILD;
            base = fix_hist;
            nbit = fix_taken;
         end else if (upd_valid && upd_tid == TID_W'(t)) begin
            act  = GH_SHIFT;
            nbit = upd_taken;
         end
      end

      ghr_hist_lane #(.HIST_W(HIST_W)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .act     (act),
         .new_bit (nbit),
         .base    (base),
         .hist    (lane_hist[t])
      );

      // R7: a dead checkpoint with no update leaves the lane alone
      a_r7_dead_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (!(upd_valid && upd_tid == TID_W'(t)) &&
          !(fix_valid && fix_live) && !(drop_valid && drop_live))
         |=> $stable(lane_hist[t]));
   end

   // R9: nothing live right after reset
   a_r9_reset_empty: assert property (@(posedge clk)
      $rose(rst_n) |-> live_map == '0);

endmodule

// File: tb/tb_ghr_spec_hist.sv
module tb_ghr_spec_hist;

   localparam int NT = 2, HW = 6, SW = 8, NC = 16, TW = 1, IW = 4;
   localparam logic [HW-1:0] MASK = '1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic upd_valid = 0, upd_taken = 0, pred_valid = 0, fix_valid = 0;
   logic fix_taken = 0, drop_valid = 0, retire_valid = 0;
   logic [TW-1:0] upd_tid = 0, pred_tid = 0, obs_tid = 0;
   logic [IW-1:0] pred_id = 0, fix_id = 0, drop_id = 0, retire_id = 0;
   logic [SW-1:0] pred_snap, obs_hist;
   logic [NC-1:0] live_map;

   int checks = 0, errors = 0;
   logic [HW-1:0] mh [NT];

   always #10 clk = ~clk;

   ghr_spec_hist #(.NUM_THREADS(NT), .HIST_W(HW), .STORE_W(SW), .NUM_CKPT(NC)) dut (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_taken(upd_taken),
      .pred_valid(pred_valid), .pred_tid(pred_tid), .pred_id(pred_id), .pred_snap(pred_snap),
      .fix_valid(fix_valid), .fix_id(fix_id), .fix_taken(fix_taken),
      .drop_valid(drop_valid), .drop_id(drop_id),
      .retire_valid(retire_valid), .retire_id(retire_id),
      .obs_tid(obs_tid), .obs_hist(obs_hist), .live_map(live_map));

   function automatic logic [HW-1:0] shl(input logic [HW-1:0] h, input logic b);
      return ((h << 1) | HW'(b)) & MASK;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clr();
      upd_valid = 0; pred_valid = 0; fix_valid = 0; drop_valid = 0; retire_valid = 0;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk); clr();
   endtask

   task automatic chk_hist(input string req, input int t);
      obs_tid = TW'(t); #1;
      chk(req, 32'(obs_hist), 32'(mh[t]));
   endtask

   task automatic upd(input int t, input logic b);
      upd_valid = 1; upd_tid = TW'(t); upd_taken = b;
      tick();
      mh[t] = shl(mh[t], b);
   endtask

   task automatic pred(input int t, input int id, output logic [HW-1:0] snap);
      pred_valid = 1; pred_tid = TW'(t); pred_id = IW'(id); #1;
      chk("R2 snapshot", 32'(pred_snap), 32'(mh[t]));
      snap = mh[t];
      tick();
      chk("R2 live", 32'(live_map[id]), 32'd1);
   endtask

   task automatic t_reset();
      chk("R9 live_map", 32'(live_map), 32'd0);
      mh[0] = '0; mh[1] = '0;
      chk_hist("R9 hist t0", 0);
      chk_hist("R9 hist t1", 1);
   endtask

   task automatic t_shift();
      logic [6:0] pat = 7'b1101101;
      for (int i = 0; i < 7; i++) begin
         upd(0, pat[i]);
         chk_hist("R1 shift", 0);
      end
      chk_hist("R8 other thread", 1);
   endtask

   task automatic t_fix_drop();
      logic [HW-1:0] s;
      // prediction with a same-cycle update: snapshot is pre-update
      upd_valid = 1; upd_tid = 0; upd_taken = 1;
      pred(0, 3, s);
      mh[0] = shl(mh[0], 1'b1);
      chk_hist("R2 same-cycle update", 0);
      upd(0, 0); upd(0, 1);
      fix_valid = 1; fix_id = 3; fix_taken = 0; tick();
      mh[0] = shl(s, 1'b0);
      chk_hist("R3 rebuild", 0);
      chk("R3 still live", 32'(live_map[3]), 32'd1);
      fix_valid = 1; fix_id = 3; fix_taken = 1; tick();
      mh[0] = shl(s, 1'b1);
      chk_hist("R3 rebuild taken", 0);
      upd(0, 1); upd(0, 1);
      drop_valid = 1; drop_id = 3; tick();
      mh[0] = s;
      chk_hist("R4 restore", 0);
      chk("R4 freed", 32'(live_map[3]), 32'd0);
      chk_hist("R8 other thread", 1);
   endtask

   task automatic t_retire();
      logic [HW-1:0] s;
      upd(1, 1); upd(1, 0); upd(1, 1);
      pred(1, 5, s);
      upd(1, 1);
      retire_valid = 1; retire_id = 5; tick();
      chk("R5 freed", 32'(live_map[5]), 32'd0);
      chk_hist("R5 t1 unchanged", 1);
      chk_hist("R5 t0 unchanged", 0);
      // discard after commit hits a dead entry
      drop_valid = 1; drop_id = 5; tick();
      chk_hist("R7 dead drop", 1);
      fix_valid = 1; fix_id = 9; fix_taken = 1; tick();
      chk_hist("R7 dead fix", 1);
   endtask

   task automatic t_priority();
      logic [HW-1:0] s7, s8;
      pred(0, 7, s7);
      upd(0, 1);
      pred(0, 8, s8);
      upd(0, 0);
      fix_valid = 1; fix_id = 7; fix_taken = 1;
      upd_valid = 1; upd_tid = 0; upd_taken = 0; tick();
      mh[0] = shl(s7, 1'b1);
      chk_hist("R6 fix over update", 0);
      drop_valid = 1; drop_id = 8;
      fix_valid = 1; fix_id = 7; fix_taken = 0;
      upd_valid = 1; upd_tid = 0; upd_taken = 1; tick();
      mh[0] = s8;
      chk_hist("R6 drop over fix", 0);
      retire_valid = 1; retire_id = 7; tick();
   endtask

   task automatic t_realloc();
      logic [HW-1:0] s_old, s_new;
      pred(1, 2, s_old);
      upd(1, 0); upd(1, 0);
      // commit and re-allocate ID 2 in one cycle
      retire_valid = 1; retire_id = 2;
      pred(1, 2, s_new);
      chk("R10 live after realloc", 32'(live_map[2]), 32'd1);
      upd(1, 1);
      drop_valid = 1; drop_id = 2; tick();
      mh[1] = s_new;
      chk_hist("R10 new snapshot", 1);
      // discard and re-allocate in one cycle
      pred(0, 4, s_old);
      drop_valid = 1; drop_id = 4;
      pred(1, 4, s_new);
      mh[0] = s_old;
      chk("R10 live after drop", 32'(live_map[4]), 32'd1);
      chk_hist("R10 drop restore", 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_shift();
      t_fix_drop();
      t_retire();
      t_priority();
      t_realloc();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule